// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits beside the command pins of a two-bank SDRAM and watches every clock edge. It decodes chip-select, RAS#, CAS# and WE# into a command, keeps a small model of each bank (idle, row open, closing under auto-precharge) and of the whole device (refresh in progress, mode register being written), and judges each command against that model and a set of minimum-spacing rules given in clock cycles.

When a command breaks a rule, the monitor raises a one-cycle `illegal` pulse with a reason code in the cycle after the offending edge. A rejected command leaves the model untouched, so the monitor keeps tracking what the device would really do. A separate per-bank pulse warns when a row has been left open past the maximum active time. The monitor is passive. It drives nothing back onto the bus and is meant for simulation benches, emulation or on-chip debug of a memory controller.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Commands decode on the edge with `cs_n` high as deselect. Otherwise {ras_n,cas_n,we_n} = 000 is mode-register write, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 no-op. Deselect, no-op and burst stop are never flagged. A flagged command shows as `illegal`=1 and a nonzero `reason` for exactly the one cycle after its edge. Otherwise `illegal`=0 and `reason`=0.
- R2: A refresh or mode-register write while either bank has a row open or closing is flagged with reason 2.
- R3: A legal refresh makes both banks report state 2 for the next TRC-1 edges. Any command other than deselect, no-op or burst stop on those edges gets reason 1. The command TRC edges after the refresh is judged normally.
- R4: A legal mode-register write makes both banks report state 3 for one edge. A non-no-op command on that edge gets reason 1. The command two edges later is judged normally.
- R5: Activate, read, write and precharge are judged only against the bank chosen by `ba`. An activate to one bank while the other has an open row is legal once the spacing of R9 holds.
- R6: A read or write fewer than TRCD edges after that bank's activate is flagged with reason 5.
- R7: A precharge fewer than TRAS_MIN edges after that bank's activate is flagged with reason 6. A legal precharge returns the bank to state 0.
- R8: If a row is still open and not closing on the edge TRAS_MAX cycles after its activate, and that edge does not close it, then `row_overdue[b]` pulses for exactly one cycle.
- R9: An activate fewer than TRRD edges after the other bank's activate is flagged with reason 7.
- R10: A legal read or write with `addr[AP_BIT]` high starts auto-precharge. The bank reads state 1 until it reports state 0 after the edge BURST_LEN-1 cycles later. While it is closing, a read or write to it gets reason 3 and an activate gets reason 4.
- R11: A read or write to an idle bank gets reason 3. An activate to a bank with a row open gets reason 4. A precharge of an idle or closing bank is legal and changes nothing.
- R12: A flagged command changes no bank or device state. Checks are applied in order: device busy first, then bank state, then spacing.
- R13: Synchronous active-high reset puts both banks in state 0, clears all pulses and sets every timer so that no spacing rule blocks the first commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM command bus |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | ADDR_W | Address bus; bit AP_BIT requests auto-precharge on read/write |
| illegal | output | 1 | One-cycle pulse for a rejected command |
| reason | output | 3 | 0 none, 1 device busy, 2 bank not idle for refresh/mode write, 3 no open row, 4 row already open, 5 TRCD, 6 TRAS min, 7 TRRD |
| bank_state | output | 4 | Two bits per bank (bank 0 in [1:0]): 0 idle, 1 active, 2 refreshing, 3 mode write |
| row_overdue | output | 2 | One-cycle pulse per bank when a row exceeds TRAS_MAX |

## Verification
The bench builds the monitor with TRC=6, TRCD=3, TRAS_MIN=5, TRAS_MAX=12, TRRD=2 and BURST_LEN=4. TRAS_MAX is shortened so that the overdue pulse appears within a short idle stretch. Because TRRD is smaller than TRCD, an activate-to-activate violation and a read-too-early violation can be produced in separate, nearby cycles. With TRC=6 there is a busy window long enough to probe both its last blocked edge and its first free edge.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

  typedef enum logic [3:0] {
    CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT,
    CMD_WR, CMD_RD, CMD_BST, CMD_NOP, CMD_DESEL
  } cmd_e;

  typedef enum logic [2:0] {
    RSN_NONE       = 3'd0,
    RSN_DEV_BUSY   = 3'd1,
    RSN_BANKS_OPEN = 3'd2,
    RSN_NO_ROW     = 3'd3,
    RSN_ROW_OPEN   = 3'd4,
    RSN_TRCD       = 3'd5,
    RSN_TRAS       = 3'd6,
    RSN_TRRD       = 3'd7
  } reason_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_REFRESH = 2'd2,
    ST_MODE    = 2'd3
  } bstate_e;

  // True once enough edges have passed since an event.
  function automatic logic reached(input int elapsed, input int min_cyc);
    return elapsed >= min_cyc;
  endfunction

endpackage

// File: rtl/sdg_decode.sv
module sdg_decode
  import sdg_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdg_devtimer.sv
module sdg_devtimer
  import sdg_pkg::*;
#(
  parameter int TRC = 6
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start_ref,
  input  logic    start_mrs,
  output bstate_e dev_st
);

  localparam int CW = $clog2(TRC + 1);
  localparam int MRS_CYC = 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_st <= ST_IDLE;
      cnt    <= '0;
    end else if (start_ref) begin
      dev_st <= ST_REFRESH;
      cnt    <= CW'(TRC - 1);
    end else if (start_mrs) begin
      dev_st <= ST_MODE;
      cnt    <= CW'(MRS_CYC - 1);
    end else if (dev_st != ST_IDLE) begin
      if (cnt == CW'(1)) begin
        dev_st <= ST_IDLE;
        cnt    <= '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  AST_REFRESH_ENDS: assert property (@(posedge clk) disable iff (rst)
    (dev_st == ST_REFRESH && cnt == CW'(1)) |=> dev_st == ST_IDLE); // R3

  AST_MODE_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
    (dev_st == ST_MODE) |=> dev_st == ST_IDLE); // R4

endmodule

// File: rtl/sdg_bank.sv
module sdg_bank
  import sdg_pkg::*;
#(
  parameter int TRCD      = 3,
  parameter int TRAS_MIN  = 5,
  parameter int TRAS_MAX  = 20,
  parameter int BURST_LEN = 4,
  parameter int AGE_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_go,
  input  logic             rw_go,
  input  logic             ap_go,
  input  logic             pre_go,
  output logic             active,
  output logic             closing,
  output logic [AGE_W-1:0] age,
  output logic             overdue
);

  localparam int SAT = TRAS_MAX + 1;
  localparam int BW  = $clog2(BURST_LEN + 1);

  logic [BW-1:0] bcnt;
  logic          row_limit_hit;

  assign row_limit_hit = active && !closing && (age == AGE_W'(TRAS_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      closing <= 1'b0;
      bcnt    <= '0;
      age     <= AGE_W'(SAT);
      overdue <= 1'b0;
    end else begin
      overdue <= row_limit_hit && !pre_go && !ap_go;

      if (act_go)                  age <= AGE_W'(1);
      else if (age != AGE_W'(SAT)) age <= age + AGE_W'(1);

      if (act_go) begin
        active <= 1'b1;
      end else if (pre_go) begin
        active <= 1'b0;
      end else if (ap_go) begin
        if (BURST_LEN == 1) begin
          active <= 1'b0;
        end else begin
          closing <= 1'b1;
          bcnt    <= BW'(BURST_LEN - 1);
        end
      end else if (closing) begin
        if (bcnt == BW'(1)) begin
          active  <= 1'b0;
          closing <= 1'b0;
        end else begin
          bcnt <= bcnt - BW'(1);
        end
      end
    end
  end

  AST_RW_AFTER_TRCD: assert property (@(posedge clk) disable iff (rst)
    rw_go |-> (active && !closing && int'(age) >= TRCD)); // R6

  AST_PRE_AFTER_TRAS: assert property (@(posedge clk) disable iff (rst)
    pre_go |-> int'(age) >= TRAS_MIN); // R7

  AST_ACT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    act_go |-> !active); // R11

  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    $fell(closing) |-> !active); // R10

  AST_OVERDUE_PULSE: assert property (@(posedge clk) disable iff (rst)
    overdue |=> !overdue); // R8

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdg_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int TRC       = 6,
  parameter int TRCD      = 3,
  parameter int TRAS_MIN  = 5,
  parameter int TRAS_MAX  = 20,
  parameter int TRRD      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              illegal,
  output logic [2:0]        reason,
  output logic [3:0]        bank_state,
  output logic [1:0]        row_overdue
);

  localparam int AGE_W = $clog2(TRAS_MAX + 2);

  cmd_e             cmd;
  bstate_e          dev_st;
  reason_e          why;
  logic             legal;
  logic             dev_busy;
  logic             is_rw;
  logic [1:0]       b_active, b_closing;
  logic [1:0]       act_go, rw_go, ap_go, pre_go;
  logic [AGE_W-1:0] b_age [2];
  logic             addr_unused;

  assign addr_unused = ^addr;

  sdg_decode u_decode (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdg_devtimer #(.TRC(TRC)) u_dev (
    .clk      (clk),
    .rst      (rst),
    .start_ref(legal && cmd == CMD_REF),
    .start_mrs(legal && cmd == CMD_MRS),
    .dev_st   (dev_st)
  );

  assign dev_busy = (dev_st != ST_IDLE);
  assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);

  // Rule evaluation: device busy, then bank state, then spacing.
  always_comb begin
    why = RSN_NONE;
    if (cmd == CMD_NOP || cmd == CMD_DESEL || cmd == CMD_BST) begin
      why = RSN_NONE;
    end else if (dev_busy) begin
      why = RSN_DEV_BUSY;
    end else begin
      case (cmd)
        CMD_MRS, CMD_REF:
          if (b_active != 2'b00) why = RSN_BANKS_OPEN;
        CMD_ACT:
          if (b_active[ba])                              why = RSN_ROW_OPEN;
          else if (!reached(int'(b_age[~ba]), TRRD))     why = RSN_TRRD;
        CMD_RD, CMD_WR:
          if (!b_active[ba] || b_closing[ba])            why = RSN_NO_ROW;
          else if (!reached(int'(b_age[ba]), TRCD))      why = RSN_TRCD;
        CMD_PRE:
          if (b_active[ba] && !b_closing[ba] &&
              !reached(int'(b_age[ba]), TRAS_MIN))       why = RSN_TRAS;
        default: why = RSN_NONE;
      endcase
    end
  end

  assign legal = (why == RSN_NONE);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign act_go[g] = legal && cmd == CMD_ACT && ba == 1'(g);
    assign rw_go[g]  = legal && is_rw && ba == 1'(g);
    assign ap_go[g]  = rw_go[g] && addr[AP_BIT];
    assign pre_go[g] = legal && cmd == CMD_PRE && ba == 1'(g) &&
                       b_active[g] && !b_closing[g];

    sdg_bank #(
      .TRCD(TRCD), .TRAS_MIN(TRAS_MIN), .TRAS_MAX(TRAS_MAX),
      .BURST_LEN(BURST_LEN), .AGE_W(AGE_W)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .act_go (act_go[g]),
      .rw_go  (rw_go[g]),
      .ap_go  (ap_go[g]),
      .pre_go (pre_go[g]),
      .active (b_active[g]),
      .closing(b_closing[g]),
      .age    (b_age[g]),
      .overdue(row_overdue[g])
    );

    assign bank_state[2*g +: 2] = dev_busy ? dev_st :
                                  (b_active[g] ? ST_ACTIVE : ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal <= 1'b0;
      reason  <= RSN_NONE;
    end else begin
      illegal <= !legal;
      reason  <= why;
    end
  end

  AST_QUIET_CMDS: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NOP || cmd == CMD_DESEL || cmd == CMD_BST) |=> !illegal); // R1

  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (rst)
    (dev_busy && !(cmd == CMD_NOP || cmd == CMD_DESEL || cmd == CMD_BST))
      |=> (illegal && reason == RSN_DEV_BUSY)); // R3

  AST_GLOBAL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_MRS || cmd == CMD_REF) && b_active != 2'b00)
      |=> illegal); // R2

endmodule

// File: tb/sdram_cmd_guard_test.sv
`timescale 1ns/1ps
module sdram_cmd_guard_test;

  localparam int TRC = 6, TRCD = 3, TRAS_MIN = 5, TRAS_MAX = 12;
  localparam int TRRD = 2, BL = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic        ba = 1'b0;
  logic [12:0] addr = '0;
  logic        illegal;
  logic [2:0]  reason;
  logic [3:0]  bank_state;
  logic [1:0]  row_overdue;

  always #10 clk = ~clk;

  sdram_cmd_guard #(
    .ADDR_W(13), .AP_BIT(10), .TRC(TRC), .TRCD(TRCD), .TRAS_MIN(TRAS_MIN),
    .TRAS_MAX(TRAS_MAX), .TRRD(TRRD), .BURST_LEN(BL)
  ) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .illegal(illegal), .reason(reason),
    .bank_state(bank_state), .row_overdue(row_overdue)
  );

  int    n_chk = 0, n_bad = 0;
  string phase = "R13";
  bit    finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_act[2], m_apc[2], m_age[2];
  int m_left, m_kind;
  int e_ill, e_rsn, e_state, e_over[2];
  int k, b, o, r, g;
  bit ap, pre_closes;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_act[i] = 0; m_apc[i] = 0; m_age[i] = 1000; e_over[i] = 0;
      end
      m_left = 0; m_kind = 0; e_ill = 0; e_rsn = 0; e_state = 0;
    end else begin
      k  = cs_n ? 8 : int'({ras_n, cas_n, we_n});
      b  = int'(ba);
      o  = 1 - b;
      ap = addr[10];
      r  = 0;
      if (k == 6 || k == 7 || k == 8)      r = 0;
      else if (m_left > 0)                 r = 1;
      else if (k == 0 || k == 1)           r = (m_act[0] != 0 || m_act[1] != 0) ? 2 : 0;
      else if (k == 3)                     r = (m_act[b] != 0) ? 4 : ((m_age[o] < TRRD) ? 7 : 0);
      else if (k == 4 || k == 5)           r = (m_act[b] == 0 || m_apc[b] > 0) ? 3 :
                                               ((m_age[b] < TRCD) ? 5 : 0);
      else if (k == 2)                     r = (m_act[b] != 0 && m_apc[b] == 0 &&
                                               m_age[b] < TRAS_MIN) ? 6 : 0;
      pre_closes = (r == 0 && k == 2 && m_act[b] != 0 && m_apc[b] == 0);
      for (int i = 0; i < 2; i++)
        e_over[i] = (m_act[i] != 0 && m_apc[i] == 0 && m_age[i] == TRAS_MAX &&
                     !(r == 0 && i == b && (k == 2 || ((k == 4 || k == 5) && ap)))) ? 1 : 0;
      if (m_left > 0) m_left--;
      for (int i = 0; i < 2; i++) begin
        if (m_apc[i] > 0) begin
          m_apc[i]--;
          if (m_apc[i] == 0) m_act[i] = 0;
        end
        if (m_age[i] < 1000) m_age[i]++;
      end
      if (r == 0) begin
        if (k == 0) begin m_left = 1;       m_kind = 3; end
        if (k == 1) begin m_left = TRC - 1; m_kind = 2; end
        if (k == 3) begin m_act[b] = 1;     m_age[b] = 1; end
        if (pre_closes) m_act[b] = 0;
        if ((k == 4 || k == 5) && ap) begin
          if (BL == 1) m_act[b] = 0;
          else         m_apc[b] = BL - 1;
        end
      end
      e_ill = (r != 0) ? 1 : 0;
      e_rsn = r;
      e_state = 0;
      for (int i = 0; i < 2; i++) begin
        g = (m_left > 0) ? m_kind : m_act[i];
        e_state = e_state | (g << (2 * i));
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(int'(illegal) == e_ill, {phase, " illegal"}, int'(illegal), e_ill);
      chk(int'(reason) == e_rsn, {phase, " reason"}, int'(reason), e_rsn);
      chk(int'(bank_state) == e_state, {phase, " bank_state"}, int'(bank_state), e_state);
      chk(int'(row_overdue) == (e_over[1] * 2 + e_over[0]), "R8 row_overdue",
          int'(row_overdue), e_over[1] * 2 + e_over[0]);
    end
  end

  // Drive a command at a negedge; return at the next negedge, where the
  // outputs already reflect it.
  task automatic issue(input int kind, input int bank, input bit autop);
    cs_n  = (kind == 8);
    {ras_n, cas_n, we_n} = (kind == 8) ? 3'b111 : 3'(kind);
    ba    = 1'(bank);
    addr  = autop ? 13'h400 : 13'h000;
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(7, 0, 0);
  endtask

  task automatic want(input int code, input string req);
    chk(int'(reason) == code && int'(illegal) == (code != 0), req, int'(reason), code);
  endtask

  int pulses;

  initial begin
    repeat (3) @(negedge clk);
    chk(bank_state == 4'b0000 && illegal == 1'b0 && row_overdue == 2'b00,
        "R13 reset state", int'(bank_state), 0);
    rst = 1'b0;
    phase = "R1";
    issue(8, 0, 0); want(0, "R1 deselect");
    issue(6, 0, 0); want(0, "R1 burst stop");
    issue(7, 0, 0);
    phase = "R11";
    issue(5, 0, 0); want(3, "R11 read idle bank");
    issue(2, 0, 0); want(0, "R11 precharge idle bank");
    phase = "R4";
    issue(0, 0, 0); want(0, "R4 mode write");
    chk(bank_state == 4'b1111, "R4 mode state", int'(bank_state), 15);
    issue(3, 0, 0); want(1, "R4 busy edge");
    issue(3, 0, 0); want(0, "R4 free after two");
    phase = "R6";
    issue(5, 0, 0); want(5, "R6 read before TRCD");
    issue(7, 0, 0);
    issue(5, 0, 0); want(0, "R6 read at TRCD");
    phase = "R5";
    issue(3, 1, 0); want(0, "R5 activate other bank");
    issue(3, 0, 0); want(4, "R11 activate open bank");
    issue(1, 0, 0); want(2, "R2 refresh with open rows");
    phase = "R7";
    issue(2, 1, 0); want(6, "R7 precharge before TRAS_MIN");
    chk(bank_state[3:2] == 2'd1, "R12 rejected precharge kept row", int'(bank_state[3:2]), 1);
    issue(2, 0, 0); want(0, "R7 precharge after TRAS_MIN");
    chk(bank_state[1:0] == 2'd0, "R7 bank idle", int'(bank_state[1:0]), 0);
    nops(3);
    issue(2, 1, 0); want(0, "R7 precharge bank1");
    phase = "R9";
    issue(3, 0, 0); want(0, "R9 first activate");
    issue(3, 1, 0); want(7, "R9 activate within TRRD");
    issue(3, 1, 0); want(0, "R9 activate at TRRD");
    phase = "R10";
    nops(2);
    issue(4, 0, 1); want(0, "R10 write with auto-precharge");
    issue(5, 0, 0); want(3, "R10 read closing bank");
    issue(3, 0, 0); want(4, "R10 activate closing bank");
    chk(bank_state[1:0] == 2'd1, "R10 still closing", int'(bank_state[1:0]), 1);
    issue(7, 0, 0);
    chk(bank_state[1:0] == 2'd0, "R10 closed", int'(bank_state[1:0]), 0);
    phase = "R8";
    issue(3, 0, 0); want(0, "R8 activate");
    issue(2, 1, 0); want(0, "R8 precharge bank1");
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      issue(7, 0, 0);
      if (row_overdue[0]) pulses++;
    end
    chk(pulses == 1, "R8 single overdue pulse", pulses, 1);
    issue(2, 0, 0); want(0, "R8 late precharge");
    phase = "R3";
    issue(1, 0, 0); want(0, "R3 refresh");
    chk(bank_state == 4'b1010, "R3 refresh state", int'(bank_state), 10);
    issue(3, 0, 0); want(1, "R3 busy activate");
    nops(TRC - 3);
    issue(3, 0, 0); want(1, "R3 last busy edge");
    issue(3, 0, 0); want(0, "R3 free after TRC");
    nops(2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule